// File: doc/BRIEF.md
# Bus-Master Ownership Latency Timer

This block sits beside a bus master's state machine and bounds how long that master may keep a shared bus once the arbiter has handed it over. Each time the grant input goes from low to high, a countdown loads from an 8-bit programmable latency value. It then drops by one on every bus clock for as long as the grant stays high.

When the count is spent, the block checks whether any competitor is queued. If another master is waiting and a transfer is in progress, it raises a release demand. If nobody is waiting, it raises a permission flag instead, so the master may keep going or take the bus straight back. The arbitration policy belongs to the arbiter and is not part of this block.

Top module: `busLatencyTimer`

## Requirements
- R1: After reset, and on any clock where grant was low at the previous rising edge, both `mustRelease` and `reRequestOk` are low.
- R2: A grant gain is grant high at a rising edge where it was low at the previous edge. At that edge the countdown loads the current `latencyValue`.
- R3: While grant stays high, the count drops by one per rising edge. The spent condition therefore holds from the N-th rising edge after the gain edge, where N is the loaded value. A value of 0 makes it hold right after the gain edge.
- R4: While spent, with grant, `xferActive` and `othersWaiting` all high, `mustRelease` is high.
- R5: The count holds at zero while grant stays high, so `mustRelease` stays asserted for as long as grant, `xferActive` and `othersWaiting` remain high.
- R6: `mustRelease` is low whenever `xferActive` is low, even when spent.
- R7: While spent with grant high and `othersWaiting` low, `reRequestOk` is high and `mustRelease` is low. The two outputs are never high together.
- R8: Dropping grant clears both outputs. If grant is lost before the count is spent, the next gain reloads the full `latencyValue`.
- R9: Changing `latencyValue` while grant is held has no effect on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| latencyValue | input | 8 | Programmed ownership budget in clocks |
| grant | input | 1 | Bus ownership granted to this master |
| othersWaiting | input | 1 | Another master requests the bus |
| xferActive | input | 1 | This master has a transaction in flight |
| mustRelease | output | 1 | Master must give up the bus |
| reRequestOk | output | 1 | Budget spent but no competitor; master may re-take the bus |

## Verification
Directed sequences use budgets of 0 and 3 to pin down the exact expiry clock. Holding grant past expiry shows that the count stays at zero rather than wrapping. Toggling `othersWaiting` and `xferActive` after expiry tells the release demand apart from the re-request permission and from the idle-owner case. A grant dropped mid-count and then regained, and a budget rewritten during ownership, separate reload-on-gain from reload-on-write. A long seeded random run mixes short and long budgets with bursty grant patterns and compares both outputs every cycle against a bench reference model.

// File: rtl/busLatencyPkg.sv
package busLatencyPkg;
  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobes_t;
endpackage

// File: rtl/busLatencyDatapath.sv
module busLatencyDatapath
  import busLatencyPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             cntZero
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (strb.load) count <= loadVal;
    else if (strb.dec)  count <= count - CNT_W'(1);
  end

  assign cntZero = (count == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> count == $past(loadVal));
  assert_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.load) |=> count == $past(count) - CNT_W'(1));
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !strb.load) |=> cntZero);
endmodule

// File: rtl/busLatencyControl.sv
module busLatencyControl
  import busLatencyPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grant,
  input  logic        othersWaiting,
  input  logic        xferActive,
  input  logic        cntZero,
  output cntStrobes_t strb,
  output logic        mustRelease,
  output logic        reRequestOk
);
  logic grantQ;
  logic gain;
  logic spent;

  always_ff @(posedge clk) begin
    if (!rstN) grantQ <= 1'b0;
    else       grantQ <= grant;
  end

  assign gain  = grant && !grantQ;
  assign spent = grantQ && grant && cntZero;

  always_comb begin
    strb.load = gain;
    strb.dec  = grant && !gain && !cntZero;
  end

  assign mustRelease = spent && xferActive && othersWaiting;
  assign reRequestOk = spent && !othersWaiting;

  assert_idle_no_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    mustRelease |-> xferActive);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(mustRelease && reRequestOk));
  assert_no_grant_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !grant |-> (!mustRelease && !reRequestOk));
  assert_gain_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !grantQ) |-> !(mustRelease || reRequestOk));
endmodule

// File: rtl/busLatencyTimer.sv
module busLatencyTimer
  import busLatencyPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] latencyValue,
  input  logic             grant,
  input  logic             othersWaiting,
  input  logic             xferActive,
  output logic             mustRelease,
  output logic             reRequestOk
);
  cntStrobes_t strb;
  logic        cntZero;

  busLatencyControl u_ctrl (
    .clk(clk), .rstN(rstN), .grant(grant), .othersWaiting(othersWaiting),
    .xferActive(xferActive), .cntZero(cntZero), .strb(strb),
    .mustRelease(mustRelease), .reRequestOk(reRequestOk)
  );

  busLatencyDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(latencyValue), .cntZero(cntZero)
  );
endmodule

// File: tb/busLatencyTimer_tb.sv
`timescale 1ns/1ps
module busLatencyTimer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] latencyValue = 8'd0;
  logic       grant = 1'b0, othersWaiting = 1'b0, xferActive = 1'b0;
  logic       mustRelease, reRequestOk;

  int checks = 0;
  int fails  = 0;
  logic       mGrantQ = 1'b0;
  logic [7:0] mCnt = 8'd0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  busLatencyTimer u_dut (
    .clk(clk), .rstN(rstN), .latencyValue(latencyValue), .grant(grant),
    .othersWaiting(othersWaiting), .xferActive(xferActive),
    .mustRelease(mustRelease), .reRequestOk(reRequestOk)
  );

  function automatic logic expMust(logic g, logic o, logic x);
    return mGrantQ && g && (mCnt == 8'd0) && x && o;
  endfunction

  function automatic logic expRe(logic g, logic o);
    return mGrantQ && g && (mCnt == 8'd0) && !o;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive at negedge, check mid-cycle, advance model at posedge.
  task automatic cyc(string tag, logic g, logic o, logic x, logic [7:0] lv);
    @(negedge clk);
    grant = g; othersWaiting = o; xferActive = x; latencyValue = lv;
    #1;
    check(tag, mustRelease, expMust(g, o, x), "mustRelease");
    check(tag, reRequestOk, expRe(g, o), "reRequestOk");
    @(posedge clk);
    if (rstN) begin
      if (g && !mGrantQ)        mCnt = lv;
      else if (g && mCnt != 0)  mCnt = mCnt - 8'd1;
      mGrantQ = g;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", mustRelease, 1'b0, "reset mustRelease");
    check("R1", reRequestOk, 1'b0, "reset reRequestOk");
    @(negedge clk); rstN = 1'b1;
    // R1: grant first seen with count at zero: no flag on gain cycle
    cyc("R1", 1, 1, 1, 8'd0);
    // R3: budget 0 spent right after gain edge
    cyc("R3", 1, 1, 1, 8'd0);
    check("R3", mustRelease, 1'b1, "zero budget release");
    cyc("R8", 0, 1, 1, 8'd0);
    // R2 R3 R4: budget 3
    cyc("R2", 1, 1, 1, 8'd3);
    cyc("R3", 1, 1, 1, 8'd3);
    check("R3", mustRelease, 1'b0, "not yet spent");
    cyc("R3", 1, 1, 1, 8'd3);
    cyc("R3", 1, 1, 1, 8'd3);
    cyc("R4", 1, 1, 1, 8'd3);
    check("R4", mustRelease, 1'b1, "spent with competitor");
    // R5: hold at zero
    for (int i = 0; i < 5; i++) cyc("R5", 1, 1, 1, 8'd3);
    check("R5", mustRelease, 1'b1, "still demanding release");
    // R6: idle owner
    cyc("R6", 1, 1, 0, 8'd3);
    check("R6", mustRelease, 1'b0, "idle owner not flagged");
    // R7: no competitor
    cyc("R7", 1, 0, 1, 8'd3);
    check("R7", reRequestOk, 1'b1, "re-request allowed");
    // R8: drop, regain, drop mid-count, regain reloads
    cyc("R8", 0, 0, 1, 8'd3);
    check("R8", reRequestOk, 1'b0, "cleared on drop");
    cyc("R8", 1, 1, 1, 8'd4);
    cyc("R8", 1, 1, 1, 8'd4);
    cyc("R8", 0, 1, 1, 8'd4);
    cyc("R8", 1, 1, 1, 8'd4);
    for (int i = 0; i < 4; i++) cyc("R8", 1, 1, 1, 8'd4);
    check("R8", mustRelease, 1'b0, "full budget reloaded");
    cyc("R8", 1, 1, 1, 8'd4);
    check("R8", mustRelease, 1'b1, "expires after reload");
    cyc("R8", 0, 1, 1, 8'd2);
    // R9: rewrite budget during ownership
    cyc("R9", 1, 1, 1, 8'd2);
    cyc("R9", 1, 1, 1, 8'd200);
    cyc("R9", 1, 1, 1, 8'd200);
    cyc("R9", 1, 1, 1, 8'd200);
    check("R9", mustRelease, 1'b1, "running count unaffected");
    cyc("R9", 0, 1, 1, 8'd200);
    // Random mix, checked against model
    for (int i = 0; i < 3000; i++) begin
      logic g, o, x;
      logic [7:0] lv;
      g  = ($urandom % 8) != 0 ? grant : ~grant;
      o  = ($urandom % 3) != 0;
      x  = ($urandom % 4) != 0;
      lv = ($urandom % 2) ? 8'($urandom % 6) : 8'($urandom);
      cyc("R4", g, o, x, lv);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule